// File: doc/BRIEF.md
# Byte-lane SDRAM word read sequencer

This block turns one 32-bit word read request into a run of byte-wide SDRAM read commands on an 8-bit external data bus. It keeps one open-row record (bank plus row). It compares each request with that record and picks one of three command sequences. A request that hits the open row gets its column reads at once. A request that misses closes the open bank with a precharge, opens the new row and waits the bank-active-to-command gap before reading. The first request after reset opens its row without a precharge.

Each word needs four column reads on consecutive columns. The byte for each read arrives a fixed number of clocks after the command. The block collects the four bytes into one little-endian word and returns it with a one-cycle completion pulse. The CPU side gives a request address and a valid strobe, and watches a busy flag. Requests that arrive while busy is high are dropped.

Top module: `sdram_rd_seq`

## Requirements
- R1: During and after reset, and with no request pending, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), clock enable is high, and busy, done and rdata are all low.
- R2: A request whose bank and row equal the open record (a hit) issues READ (0101) in the four cycles right after acceptance. Each READ carries the request bank and A10 low. A0..A9 carry column {word column, byte index}, with the byte index counting 0 to 3.
- R3: On a miss while a row is open, the cycle after acceptance shows PRECHARGE (0010) to the previously open bank with A10 low. The next cycle shows ACTIVE (0011) with the new bank, row bit 10 on A10 and row bits 9..0 on A0..A9.
- R4: The first request after reset is treated as a miss, even when its row matches the row open before reset. It issues ACTIVE in the cycle after acceptance, with no PRECHARGE.
- R5: The first READ after an ACTIVE comes exactly BCW cycles after it (BCW = 2), and the four READs run back to back.
- R6: The byte for a READ shown on the pins in cycle n is taken from the data input at the end of cycle n + LAT (LAT = 2).
- R7: done is high for exactly one cycle, LAT + 1 cycles after the last READ. In that cycle rdata holds the four bytes little-endian: the byte from column index 0 is in bits 7..0 and the byte from index 3 is in bits 31..24.
- R8: busy is high from the cycle after acceptance until done. A request strobe that arrives while busy is high is ignored: it changes neither the command trace nor the open-row record.
- R9: After any ACTIVE the open record holds that bank and row. The request address is {bank[20:19], row[18:8], word column[7:0]}. A request that differs in bank alone or in row alone is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Word read request strobe |
| req_addr | input | 21 | {bank, row, word column} |
| busy | output | 1 | Access in progress; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled word, valid with done |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a10 | output | 1 | Address line 10 |
| sd_a_lo | output | 10 | Address lines 9..0 |
| sd_dq_in | input | 8 | Read data from the SDRAM |

## Verification
Two situations are hard to reach from the ports. The first is a precharge to one bank followed by an activate of another, where the closed bank must be the old record and not the new request. The bench walks a vector table that switches bank with the row held, then switches row with the bank held. It checks every cycle of the command trace against a bank-aware memory model, which returns wrong data if a row was never opened. The second is a stale open record across reset, and a request strobe held high during an access. The bench resets in the middle of an access and then requests the same row again. It also holds a different address on the strobe through the early cycles of a miss, then sends a hit that would fail if that address had been taken.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_GAP,
    ST_READ,
    ST_LATE
  } seq_state_e;

endpackage

// File: rtl/sdram_page_track.sv
module sdram_page_track #(
  parameter int BA_W  = 2,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BA_W-1:0]  req_ba,
  input  logic [ROW_W-1:0] req_row,
  input  logic             open_we,
  input  logic [BA_W-1:0]  new_ba,
  input  logic [ROW_W-1:0] new_row,
  output logic             page_hit,
  output logic             open_valid,
  output logic [BA_W-1:0]  open_ba
);

  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_valid <= 1'b0;
      open_ba    <= '0;
      open_row   <= '0;
    end else if (open_we) begin
      open_valid <= 1'b1;
      open_ba    <= new_ba;
      open_row   <= new_row;
    end
  end

  assign page_hit = open_valid && (open_ba == req_ba) && (open_row == req_row);

endmodule

// File: rtl/sdram_rd_fsm.sv
module sdram_rd_fsm
  import sdram_rd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 11,
  parameter int A_LO_W = 10,
  parameter int WCOL_W = 8,
  parameter int BIDX_W = 2,
  parameter int NBYTES = 4,
  parameter int BCW    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_ba,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [WCOL_W-1:0] req_wcol,
  input  logic              page_hit,
  input  logic              open_valid,
  input  logic [BA_W-1:0]   open_ba,
  input  logic              last_capture,
  output logic              busy,
  output logic              open_we,
  output logic [BA_W-1:0]   new_ba,
  output logic [ROW_W-1:0]  new_row,
  output logic              rd_issue,
  output logic [BIDX_W-1:0] rd_idx,
  output sd_cmd_e           cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic              a10_q,
  output logic [A_LO_W-1:0] a_lo_q
);

  localparam int WCNT_W    = (BCW > 1) ? $clog2(BCW + 1) : 1;
  localparam int WAIT_LAST = (BCW > 1) ? BCW - 2 : 0;
  localparam int LAST_IDX  = NBYTES - 1;

  seq_state_e        state_q, state_d;
  logic [BIDX_W-1:0] idx_q, idx_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [BA_W-1:0]   lat_ba;
  logic [ROW_W-1:0]  lat_row;
  logic [WCOL_W-1:0] lat_wcol;
  logic              accept;
  logic [BA_W-1:0]   eff_ba;
  logic [ROW_W-1:0]  eff_row;
  logic [WCOL_W-1:0] eff_wcol;

  sd_cmd_e           cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic              a10_d;
  logic [A_LO_W-1:0] a_lo_d;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign eff_ba   = accept ? req_ba   : lat_ba;
  assign eff_row  = accept ? req_row  : lat_row;
  assign eff_wcol = accept ? req_wcol : lat_wcol;

  always_comb begin
    state_d = state_q;
    idx_d   = '0;
    wcnt_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (page_hit)        state_d = ST_READ;
          else if (open_valid) state_d = ST_PRE;
          else                 state_d = ST_ACT;
        end
      end
      ST_PRE:  state_d = ST_ACT;
      ST_ACT:  state_d = (BCW > 1) ? ST_GAP : ST_READ;
      ST_GAP: begin
        wcnt_d = wcnt_q + 1'b1;
        if (wcnt_q == WCNT_W'(WAIT_LAST)) state_d = ST_READ;
      end
      ST_READ: begin
        if (idx_q == BIDX_W'(LAST_IDX)) begin
          state_d = ST_LATE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_LATE: if (last_capture) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    a10_d  = 1'b0;
    a_lo_d = '0;
    unique case (state_d)
      ST_PRE: begin
        cmd_d = CMD_PRE;
        ba_d  = open_ba;
      end
      ST_ACT: begin
        cmd_d  = CMD_ACT;
        ba_d   = eff_ba;
        a10_d  = eff_row[ROW_W-1];
        a_lo_d = eff_row[A_LO_W-1:0];
      end
      ST_READ: begin
        cmd_d  = CMD_RD;
        ba_d   = eff_ba;
        a_lo_d = A_LO_W'({eff_wcol, idx_d});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      wcnt_q   <= '0;
      lat_ba   <= '0;
      lat_row  <= '0;
      lat_wcol <= '0;
      cmd_q    <= CMD_NOP;
      ba_q     <= '0;
      a10_q    <= 1'b0;
      a_lo_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
      if (accept) begin
        lat_ba   <= req_ba;
        lat_row  <= req_row;
        lat_wcol <= req_wcol;
      end
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      a10_q  <= a10_d;
      a_lo_q <= a_lo_d;
    end
  end

  assign open_we  = (state_d == ST_ACT);
  assign new_ba   = eff_ba;
  assign new_row  = eff_row;
  assign busy     = (state_q != ST_IDLE);
  assign rd_issue = (state_q == ST_READ);
  assign rd_idx   = idx_q;

endmodule

// File: rtl/sdram_byte_gather.sv
module sdram_byte_gather #(
  parameter int DQ_W   = 8,
  parameter int NBYTES = 4,
  parameter int BIDX_W = 2,
  parameter int LAT    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_issue,
  input  logic [BIDX_W-1:0]      rd_idx,
  input  logic [DQ_W-1:0]        dq_in,
  output logic                   last_capture,
  output logic                   done_q,
  output logic [DQ_W*NBYTES-1:0] rdata_q
);

  localparam int WORD_W   = DQ_W * NBYTES;
  localparam int LAST_IDX = NBYTES - 1;

  logic              v_q [LAT];
  logic [BIDX_W-1:0] i_q [LAT];
  logic [WORD_W-1:0] buf_q, merged;
  logic              cap;
  logic [BIDX_W-1:0] cidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q[0] <= 1'b0;
      i_q[0] <= '0;
    end else begin
      v_q[0] <= rd_issue;
      i_q[0] <= rd_idx;
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[g] <= 1'b0;
        i_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        i_q[g] <= i_q[g-1];
      end
    end
  end

  assign cap          = v_q[LAT-1];
  assign cidx         = i_q[LAT-1];
  assign last_capture = cap && (cidx == BIDX_W'(LAST_IDX));

  always_comb begin
    merged = buf_q;
    merged[int'(cidx)*DQ_W +: DQ_W] = dq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cap) buf_q <= merged;
      if (last_capture) begin
        rdata_q <= merged;
        done_q  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int A_LO_W = 10,
  parameter int DQ_W   = 8,
  parameter int NBYTES = 4,
  parameter int BCW    = 2,
  parameter int LAT    = 2,
  localparam int BIDX_W = $clog2(NBYTES),
  localparam int WCOL_W = COL_W - BIDX_W,
  localparam int ADDR_W = BA_W + ROW_W + WCOL_W,
  localparam int WORD_W = DQ_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_a10,
  output logic [A_LO_W-1:0] sd_a_lo,
  input  logic [DQ_W-1:0]   sd_dq_in
);

  logic [BA_W-1:0]   req_ba;
  logic [ROW_W-1:0]  req_row;
  logic [WCOL_W-1:0] req_wcol;
  logic              page_hit, open_valid, open_we, last_capture, rd_issue;
  logic [BA_W-1:0]   open_ba, new_ba;
  logic [ROW_W-1:0]  new_row;
  logic [BIDX_W-1:0] rd_idx;
  sd_cmd_e           cmd_q;
  logic              cke_q;

  assign {req_ba, req_row, req_wcol} = req_addr;

  sdram_page_track #(.BA_W(BA_W), .ROW_W(ROW_W)) u_track (
    .clk(clk), .rst(rst),
    .req_ba(req_ba), .req_row(req_row),
    .open_we(open_we), .new_ba(new_ba), .new_row(new_row),
    .page_hit(page_hit), .open_valid(open_valid), .open_ba(open_ba)
  );

  sdram_rd_fsm #(
    .BA_W(BA_W), .ROW_W(ROW_W), .A_LO_W(A_LO_W), .WCOL_W(WCOL_W),
    .BIDX_W(BIDX_W), .NBYTES(NBYTES), .BCW(BCW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ba(req_ba), .req_row(req_row), .req_wcol(req_wcol),
    .page_hit(page_hit), .open_valid(open_valid), .open_ba(open_ba),
    .last_capture(last_capture),
    .busy(busy), .open_we(open_we), .new_ba(new_ba), .new_row(new_row),
    .rd_issue(rd_issue), .rd_idx(rd_idx),
    .cmd_q(cmd_q), .ba_q(sd_ba), .a10_q(sd_a10), .a_lo_q(sd_a_lo)
  );

  sdram_byte_gather #(
    .DQ_W(DQ_W), .NBYTES(NBYTES), .BIDX_W(BIDX_W), .LAT(LAT)
  ) u_gather (
    .clk(clk), .rst(rst),
    .rd_issue(rd_issue), .rd_idx(rd_idx), .dq_in(sd_dq_in),
    .last_capture(last_capture), .done_q(done), .rdata_q(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= 1'b1;
  end

  assign sd_cke = cke_q;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk
  import sdram_rd_pkg::*;
#(
  parameter int BCW = 2
) (
  input logic clk,
  input logic rst,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_a10,
  input logic busy,
  input logic done
);

  logic [3:0]  pins;
  logic        pending;
  int unsigned since_act;

  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      since_act <= 0;
    end else if (pins == CMD_ACT) begin
      pending   <= 1'b1;
      since_act <= 1;
    end else if (pins == CMD_RD) begin
      pending   <= 1'b0;
    end else if (pending) begin
      since_act <= since_act + 1;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pins == CMD_NOP && !busy && !done));

  p_pins_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_NOP) || (pins == CMD_ACT) || (pins == CMD_RD) || (pins == CMD_PRE));

  p_read_no_autopre_r2: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_RD) |-> !sd_a10);

  p_pre_single_bank_r3: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_PRE) |-> !sd_a10);

  p_pre_then_act_r3: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_PRE) |=> (pins == CMD_ACT));

  p_bcw_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (pins == CMD_RD && pending) |-> (since_act == BCW));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_cmd_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (pins != CMD_NOP) |-> busy);

endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.BCW(BCW)) u_chk (
  .clk(clk), .rst(rst),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_a10(sd_a10), .busy(busy), .done(done)
);

// File: tb/tb_sdram_rd_seq.sv
module tb_sdram_rd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int BCW = 2;
  localparam int LAT = 2;
  localparam int K_HIT = 0, K_FIRST = 1, K_MISS = 2;
  localparam int NVEC = 9;

  // {bank[1:0], row[10:0], word column[7:0], kind[1:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd1, 11'h123, 8'h10, 2'd1},
    {2'd1, 11'h123, 8'h11, 2'd0},
    {2'd1, 11'h123, 8'hFF, 2'd0},
    {2'd1, 11'h456, 8'h00, 2'd2},
    {2'd2, 11'h456, 8'h05, 2'd2},
    {2'd2, 11'h456, 8'h06, 2'd0},
    {2'd0, 11'h7FF, 8'h80, 2'd2},
    {2'd0, 11'h000, 8'h80, 2'd2},
    {2'd0, 11'h000, 8'h01, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [20:0] req_addr = '0;
  logic        busy, done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;
  logic [31:0] rdata;
  logic [1:0]  sd_ba;
  logic [9:0]  sd_a_lo;
  logic [7:0]  sd_dq_in;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 1'b0;
  logic [1:0] bopen_ba = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_rd_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .rdata(rdata),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a10(sd_a10), .sd_a_lo(sd_a_lo),
    .sd_dq_in(sd_dq_in)
  );

  function automatic logic [7:0] mem_byte(input logic [1:0] ba, input logic [10:0] row,
                                          input logic [9:0] col);
    return row[7:0] ^ col[7:0] ^ {ba, row[10:8], 1'b1, col[9:8]};
  endfunction

  // Bank-aware SDRAM read model with LAT-cycle data return
  logic [10:0] mrow [4];
  logic [7:0]  stg [LAT];
  always @(posedge clk) begin
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011) mrow[sd_ba] <= {sd_a10, sd_a_lo};
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101)
      stg[0] <= mem_byte(sd_ba, mrow[sd_ba], sd_a_lo);
    else
      stg[0] <= 8'hEE;
    for (int k = 1; k < LAT; k++) stg[k] <= stg[k-1];
  end
  assign sd_dq_in = stg[LAT-1];

  task automatic check_idle(input string tag);
    n_tests++;
    if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} !== 4'b0111 || sd_cke !== 1'b1 ||
        busy !== 1'b0 || done !== 1'b0 || rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL %s idle state: pins=%b cke=%b busy=%b done=%b rdata=%h, expected 0111 1 0 0 00000000",
               tag, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, sd_cke, busy, done, rdata);
    end
  endtask

  task automatic run_req(input logic [1:0] ba, input logic [10:0] row, input logic [7:0] wcol,
                         input int kind, input bit inject, input string tag);
    int r0, act_r, done_r;
    logic [31:0] expw;
    logic [3:0]  e_cmd, a_cmd;
    logic [1:0]  e_ba;
    logic        e_a10;
    logic [9:0]  e_alo;
    bit tr_bad, dn_bad, bz_bad;
    r0     = (kind == K_HIT) ? 1 : ((kind == K_FIRST) ? 1 + BCW : 2 + BCW);
    act_r  = r0 - BCW;
    done_r = r0 + 3 + LAT + 1;
    for (int i = 0; i < 4; i++) expw[i*8 +: 8] = mem_byte(ba, row, {wcol, i[1:0]});
    tr_bad = 0; dn_bad = 0; bz_bad = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {ba, row, wcol};
    for (int r = 1; r <= done_r + 3; r++) begin
      @(negedge clk);
      if (r == 1) begin
        if (inject) req_addr = {~ba, row ^ 11'h055, wcol + 8'd1};
        else        req_valid = 1'b0;
      end
      if (r == 3) req_valid = 1'b0;
      e_cmd = 4'b0111; e_ba = '0; e_a10 = 1'b0; e_alo = '0;
      if (kind == K_MISS && r == 1) begin
        e_cmd = 4'b0010; e_ba = bopen_ba;
      end else if (kind != K_HIT && r == act_r) begin
        e_cmd = 4'b0011; e_ba = ba; e_a10 = row[10]; e_alo = row[9:0];
      end else if (r >= r0 && r <= r0 + 3) begin
        e_cmd = 4'b0101; e_ba = ba; e_alo = {wcol, 2'(r - r0)};
      end
      a_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!tr_bad && (a_cmd !== e_cmd ||
          (e_cmd == 4'b0010 && (sd_ba !== e_ba || sd_a10 !== 1'b0)) ||
          (e_cmd != 4'b0111 && e_cmd != 4'b0010 &&
           (sd_ba !== e_ba || sd_a10 !== e_a10 || sd_a_lo !== e_alo)))) begin
        tr_bad = 1;
        $display("FAIL %s/R5 trace cycle %0d: cmd=%b ba=%0d a10=%b a=%h, expected cmd=%b ba=%0d a10=%b a=%h",
                 tag, r, a_cmd, sd_ba, sd_a10, sd_a_lo, e_cmd, e_ba, e_a10, e_alo);
      end
      if (!dn_bad && done !== (r == done_r)) begin
        dn_bad = 1;
        $display("FAIL R7 done timing cycle %0d: done=%b, expected %b", r, done, (r == done_r));
      end
      if (!bz_bad && ((r == 1 && busy !== 1'b1) || (r == done_r && busy !== 1'b0))) begin
        bz_bad = 1;
        $display("FAIL R8 busy cycle %0d: busy=%b, expected %b", r, busy, (r == 1));
      end
      if (r == done_r) begin
        n_tests++;
        if (rdata !== expw) begin
          n_fail++;
          $display("FAIL R6/R7 %s data: rdata=%h, expected %h", tag, rdata, expw);
        end
      end
    end
    n_tests += 3;
    n_fail  += int'(tr_bad) + int'(dn_bad) + int'(bz_bad);
    bopen_ba = ba;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int v = 0; v < NVEC; v++) begin
      automatic logic [22:0] e = VEC[v];
      automatic string tg = (e[1:0] == 2'd0) ? "R2/R9 hit" :
                            (e[1:0] == 2'd1) ? "R4 first" : "R3/R9 miss";
      run_req(e[22:21], e[20:10], e[9:2], int'(e[1:0]), 1'b0, tg);
    end

    // Reset in the middle of an access; open record must be forgotten (R4)
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {2'd3, 11'h100, 8'h20};
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check_idle("R1 after mid-access reset");
    run_req(2'd3, 11'h100, 8'h21, K_FIRST, 1'b0, "R4 same row after reset");

    // Strobe held with another address during a miss (R8), then a hit
    run_req(2'd0, 11'h2AA, 8'h7F, K_MISS, 1'b1, "R8 miss with strobe held");
    run_req(2'd0, 11'h2AA, 8'h80, K_HIT, 1'b0, "R8/R9 hit after ignored strobe");

    repeat (3) @(negedge clk);
    n_tests++;
    if (busy !== 1'b0 || done !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 quiet after runs: busy=%b done=%b, expected 0 0", busy, done);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired, expected run to finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule